// File: doc/BRIEF.md
# Lazy Condition-Flag Evaluator

This block rebuilds the negative, zero, carry and overflow flags on demand from a compact record of the last flag-setting operation. It does not keep the flags themselves. The record is a 4-bit operation tag and three data words. Each tag gives the three words its own meaning: an operand pair with an optional carry-in, a finished result with flags carried over from earlier, or a flag nibble to copy. The block also tests a 4-bit branch condition against the rebuilt flags, so one lookup answers both "what are the flags" and "is this branch taken".

The tag and the condition arrive together on one 8-bit select input: the condition code sits in bits 7:4 and the operation tag in bits 3:0. With the default `REG_OUT = 1`, a request marked by `in_valid` gives its result one clock later, marked by `out_valid`. The outputs then hold until the next request. With `REG_OUT = 0` the block is purely combinational and `out_valid` follows `in_valid`.

Top module: `lzf_flag_eval`

## Requirements
- R1: `flags_word` carries N in bit 31, Z in bit 30, C in bit 29 and V in bit 28, and its bits 27:0 are always zero.
- R2: Tag 0 (copy) takes N, Z, C and V from bits 31..28 of `dep1` and ignores the other bits of `dep1`, as well as `dep2` and `dep3`.
- R3: Tags 1 (add) and 3 (add with carry) form `dep1 + dep2 + cin`. Here cin is 0 for tag 1 and `dep3[0]` for tag 3. N is bit 31 of the sum and Z is set when the 32-bit sum is zero. C is the carry out of bit 31, and V is set on signed overflow.
- R4: Tags 2 (subtract) and 4 (subtract with borrow) form `dep1 - dep2 - b`. Here b is 0 for tag 2 and `NOT dep3[0]` for tag 4. C is set when `dep1 >= dep2 + b` taken unsigned, that is, when no borrow occurs. V is set on signed overflow, and N and Z come from the 32-bit difference.
- R5: Tag 5 (logic) takes N and Z from `dep1`, C from `dep2[0]` and V from `dep3[0]`.
- R6: Tag 6 (multiply) takes N and Z from `dep1`, and carries C from `dep3[1]` and V from `dep3[0]`.
- R7: Tag 7 (long multiply) treats `{dep2, dep1}` as a 64-bit result. N is bit 63, and Z is set only when all 64 bits are zero. C comes from `dep3[1]` and V from `dep3[0]`.
- R8: A tag of 8 to 15 gives all-zero flags and raises `op_bad`. The condition is then tested against those zero flags. For tags 0 to 7, `op_bad` is low.
- R9: Conditions 0 to 7 test a single flag: 0 Z=1, 1 Z=0, 2 C=1, 3 C=0, 4 N=1, 5 N=0, 6 V=1, 7 V=0. Condition 14 is always true and condition 15 is always false.
- R10: Conditions 8 to 13 combine flags: 8 C=1 and Z=0, 9 its complement, 10 N=V, 11 N≠V, 12 Z=0 and N=V, 13 its complement.
- R11: With `REG_OUT = 1`, each cycle with `in_valid` high produces exactly one `out_valid` pulse in the next cycle. In cycles without a request, `out_valid` is low and the outputs keep the last result, whatever the data inputs do.
- R12: While `rst_n` is low, `out_valid`, `flags_word`, `cond_true` and `op_bad` are zero at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| sel_in | input | 8 | Condition code in bits 7:4, operation tag in bits 3:0 |
| dep1 | input | DATA_W | First record word |
| dep2 | input | DATA_W | Second record word |
| dep3 | input | DATA_W | Third record word (carry/overflow bits) |
| out_valid | output | 1 | Result strobe |
| flags_word | output | DATA_W | Rebuilt flags in the top four bits |
| cond_true | output | 1 | Condition outcome |
| op_bad | output | 1 | Operation tag out of range |

## Verification
The bench builds the block with `DATA_W = 32` and `REG_OUT = 1`. This brings within reach the one-cycle result timing and the hold behaviour of the output register, along with the boundaries of real 32-bit arithmetic. Every valid tag is driven with operands drawn from 0, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF, and with both carry-in values. Signed overflow, carry out and borrow are each checked at their exact edges. The copy tag then walks through all sixteen flag nibbles against all sixteen condition codes, and the out-of-range tags are run against the unconditional codes.

// File: rtl/lzf_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, operation tags, condition codes and the flag
// nibble type of the lazy flag evaluator. Assumes 4-bit tag and condition fields.
package lzf_pkg;
    localparam int TAG_W  = 4;
    localparam int COND_W = 4;
    localparam int SEL_W  = TAG_W + COND_W;

    localparam logic [TAG_W-1:0] TAG_COPY  = 4'd0;
    localparam logic [TAG_W-1:0] TAG_ADD   = 4'd1;
    localparam logic [TAG_W-1:0] TAG_SUB   = 4'd2;
    localparam logic [TAG_W-1:0] TAG_ADC   = 4'd3;
    localparam logic [TAG_W-1:0] TAG_SBB   = 4'd4;
    localparam logic [TAG_W-1:0] TAG_LOGIC = 4'd5;
    localparam logic [TAG_W-1:0] TAG_MUL   = 4'd6;
    localparam logic [TAG_W-1:0] TAG_MULL  = 4'd7;
    localparam logic [TAG_W-1:0] TAG_LAST  = TAG_MULL;

    localparam logic [COND_W-1:0] CC_ALWAYS = 4'd14;
    localparam logic [COND_W-1:0] CC_NEVER  = 4'd15;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    typedef struct packed {
        nzcv_t flags;
        logic  hit;
        logic  bad;
    } result_t;
endpackage

// File: rtl/lzf_flag_calc.sv
`timescale 1ns/1ps
// Module: lzf_flag_calc
// Rebuilds N, Z, C and V from an operation tag and three record words.
// One shared adder serves add, add-with-carry, subtract and subtract-with-borrow.
// Subtraction is done as dep1 + ~dep2 + carry, so the carry out is "no borrow".
// Assumes DATA_W >= 4. Purely combinational.
module lzf_flag_calc
    import lzf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [TAG_W-1:0]  tag,
    input  logic [DATA_W-1:0] dep1,
    input  logic [DATA_W-1:0] dep2,
    input  logic [DATA_W-1:0] dep3,
    output nzcv_t             flags,
    output logic              tag_bad
);
    localparam int MSB = DATA_W - 1;

    logic              is_sub;
    logic              cin_eff;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   sum;
    logic              add_ovf;
    logic              d1_zero;
    logic              d2_zero;
    logic [DATA_W-3:0] unused_dep3_hi;

    assign unused_dep3_hi = dep3[DATA_W-1:2];

    // Operand conditioning: invert the right operand for subtracts, pick carry-in.
    always_comb begin
        is_sub = (tag == TAG_SUB) || (tag == TAG_SBB);
        b_eff  = is_sub ? ~dep2 : dep2;
        case (tag)
            TAG_SUB:          cin_eff = 1'b1;
            TAG_ADC, TAG_SBB: cin_eff = dep3[0];
            default:          cin_eff = 1'b0;
        endcase
    end

    // Shared wide adder with signed-overflow detection.
    always_comb begin
        sum     = {1'b0, dep1} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin_eff};
        add_ovf = (dep1[MSB] == b_eff[MSB]) && (sum[MSB] != dep1[MSB]);
        d1_zero = ~|dep1;
        d2_zero = ~|dep2;
    end

    // Per-tag flag selection.
    always_comb begin
        flags   = '0;
        tag_bad = 1'b0;
        case (tag)
            TAG_COPY: begin
                flags = dep1[MSB -: 4];
            end
            TAG_ADD, TAG_SUB, TAG_ADC, TAG_SBB: begin
                flags.n = sum[MSB];
                flags.z = ~|sum[MSB:0];
                flags.c = sum[DATA_W];
                flags.v = add_ovf;
            end
            TAG_LOGIC: begin
                flags.n = dep1[MSB];
                flags.z = d1_zero;
                flags.c = dep2[0];
                flags.v = dep3[0];
            end
            TAG_MUL: begin
                flags.n = dep1[MSB];
                flags.z = d1_zero;
                flags.c = dep3[1];
                flags.v = dep3[0];
            end
            TAG_MULL: begin
                flags.n = dep2[MSB];
                flags.z = d1_zero && d2_zero;
                flags.c = dep3[1];
                flags.v = dep3[0];
            end
            default: begin
                tag_bad = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/lzf_cond_eval.sv
`timescale 1ns/1ps
// Module: lzf_cond_eval
// Tests a 4-bit condition code against a flag nibble. Codes come in pairs:
// bits 3:1 pick a base test, and bit 0 inverts it. The pair 14/15 has a base of
// constant one, so 14 is always true and 15 never. Purely combinational.
module lzf_cond_eval
    import lzf_pkg::*;
(
    input  logic [COND_W-1:0] cond,
    input  nzcv_t             flags,
    output logic              hit
);
    logic base;

    // Base test for each condition pair.
    always_comb begin
        case (cond[3:1])
            3'd0:    base = flags.z;
            3'd1:    base = flags.c;
            3'd2:    base = flags.n;
            3'd3:    base = flags.v;
            3'd4:    base = flags.c && !flags.z;
            3'd5:    base = (flags.n == flags.v);
            3'd6:    base = !flags.z && (flags.n == flags.v);
            default: base = 1'b1;
        endcase
    end

    // Odd codes take the complement of the base test.
    always_comb hit = base ^ cond[0];
endmodule

// File: rtl/lzf_out_stage.sv
`timescale 1ns/1ps
// Module: lzf_out_stage
// Output stage. With REG_OUT = 1 it registers the result on each request and
// holds it between requests. With REG_OUT = 0 it passes the result straight
// through. Synchronous active-low reset clears the register.
module lzf_out_stage
    import lzf_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    in_valid,
    input  result_t d,
    output logic    out_valid,
    output result_t q
);
    if (REG_OUT) begin : g_reg
        result_t q_r;
        logic    vld_r;

        // Capture the result on a request; otherwise hold it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_r   <= '0;
                vld_r <= 1'b0;
            end else begin
                vld_r <= in_valid;
                if (in_valid) q_r <= d;
            end
        end

        assign q         = q_r;
        assign out_valid = vld_r;

        assert_one_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
        assert_no_spurious_R11: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid && $stable(q));
    end else begin : g_comb
        logic unused_clk_rst;
        assign unused_clk_rst = clk ^ rst_n;
        assign q              = d;
        assign out_valid      = in_valid;
    end
endmodule

// File: rtl/lzf_flag_eval.sv
`timescale 1ns/1ps
// Module: lzf_flag_eval (top)
// Lazy condition-flag evaluator. It splits sel_in into the condition code
// (bits 7:4) and the operation tag (bits 3:0), rebuilds the flags from the
// record words and tests the condition. The result goes out through a
// registered or pass-through stage. Assumes DATA_W >= 4.
module lzf_flag_eval
    import lzf_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [SEL_W-1:0]  sel_in,
    input  logic [DATA_W-1:0] dep1,
    input  logic [DATA_W-1:0] dep2,
    input  logic [DATA_W-1:0] dep3,
    output logic              out_valid,
    output logic [DATA_W-1:0] flags_word,
    output logic              cond_true,
    output logic              op_bad
);
    localparam int MSB = DATA_W - 1;

    logic [TAG_W-1:0]  tag;
    logic [COND_W-1:0] cond;
    nzcv_t             flags;
    logic              tag_bad;
    logic              hit;
    result_t           res_d;
    result_t           res_q;

    // Field split of the packed select input.
    assign tag  = sel_in[TAG_W-1:0];
    assign cond = sel_in[SEL_W-1:TAG_W];

    lzf_flag_calc #(.DATA_W(DATA_W)) u_calc (
        .tag     (tag),
        .dep1    (dep1),
        .dep2    (dep2),
        .dep3    (dep3),
        .flags   (flags),
        .tag_bad (tag_bad)
    );

    lzf_cond_eval u_cond (
        .cond  (cond),
        .flags (flags),
        .hit   (hit)
    );

    assign res_d = '{flags: flags, hit: hit, bad: tag_bad};

    lzf_out_stage #(.REG_OUT(REG_OUT)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .d         (res_d),
        .out_valid (out_valid),
        .q         (res_q)
    );

    // Flag nibble placed in the top bits, low bits tied to zero.
    assign flags_word = {res_q.flags, {(DATA_W-4){1'b0}}};
    assign cond_true  = res_q.hit;
    assign op_bad     = res_q.bad;

    if (REG_OUT) begin : g_chk
        assert_copy_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && tag == TAG_COPY |=> flags_word[MSB -: 4] == $past(dep1[MSB -: 4]));
        assert_logic_cv_R5: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && tag == TAG_LOGIC |=>
                flags_word[MSB-2] == $past(dep2[0]) && flags_word[MSB-3] == $past(dep3[0]));
        assert_mul_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && (tag == TAG_MUL || tag == TAG_MULL) |=>
                flags_word[MSB-2 -: 2] == $past(dep3[1:0]));
        assert_mull_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && tag == TAG_MULL |=> flags_word[MSB] == $past(dep2[MSB]));
        assert_bad_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> op_bad == ($past(tag) > TAG_LAST));
        assert_bad_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
            op_bad |-> flags_word[MSB -: 4] == 4'b0000);
        assert_always_R9: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && cond == CC_ALWAYS |=> cond_true);
        assert_never_R9: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && cond == CC_NEVER |=> !cond_true);
    end
endmodule

// File: tb/lzf_flag_eval_test.sv
`timescale 1ns/1ps
// Scoreboard bench for lzf_flag_eval: a driver task pushes reference results
// into a queue, and a monitor pops them as out_valid pulses arrive.
module lzf_flag_eval_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  sel_in = '0;
    logic [31:0] dep1 = '0, dep2 = '0, dep3 = '0;
    logic        out_valid;
    logic [31:0] flags_word;
    logic        cond_true;
    logic        op_bad;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [31:0] word;
        logic        ct;
        logic        err;
        string       tag;
    } exp_t;

    exp_t        sbq[$];
    logic [31:0] last_word;
    logic        last_ct, last_err;

    always #10 clk = ~clk;

    lzf_flag_eval #(.DATA_W(32), .REG_OUT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sel_in(sel_in),
        .dep1(dep1), .dep2(dep2), .dep3(dep3), .out_valid(out_valid),
        .flags_word(flags_word), .cond_true(cond_true), .op_bad(op_bad)
    );

    // Reference flags {err, n, z, c, v} from plain 33-bit and 64-bit arithmetic.
    function automatic logic [4:0] ref_flags(input logic [3:0] op, input logic [31:0] a,
                                             input logic [31:0] b, input logic [31:0] c);
        logic [32:0] s;
        logic [31:0] r;
        longint      sr;
        longint      sa, sb;
        logic        k;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        case (op)
            4'd0: return {1'b0, a[31:28]};
            4'd1, 4'd3: begin
                k  = (op == 4'd3) ? c[0] : 1'b0;
                s  = {1'b0, a} + {1'b0, b} + {32'd0, k};
                r  = s[31:0];
                sr = sa + sb + longint'(k);
                return {1'b0, r[31], r == 32'd0, s[32], (sr > 64'sd2147483647) || (sr < -64'sd2147483648)};
            end
            4'd2, 4'd4: begin
                k  = (op == 4'd4) ? !c[0] : 1'b0;
                r  = a - b - {31'd0, k};
                sr = sa - sb - longint'(k);
                return {1'b0, r[31], r == 32'd0, {1'b0, a} >= ({1'b0, b} + {32'd0, k}),
                        (sr > 64'sd2147483647) || (sr < -64'sd2147483648)};
            end
            4'd5: return {1'b0, a[31], a == 32'd0, b[0], c[0]};
            4'd6: return {1'b0, a[31], a == 32'd0, c[1], c[0]};
            4'd7: return {1'b0, b[31], {b, a} == 64'd0, c[1], c[0]};
            default: return 5'b10000;
        endcase
    endfunction

    // Reference condition outcome, one code at a time.
    function automatic logic ref_cond(input logic [3:0] cc, input logic [3:0] f);
        logic n, z, c, v;
        {n, z, c, v} = f;
        case (cc)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return c;
            4'd3:  return !c;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return c && !z;
            4'd9:  return !c || z;
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            4'd14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string op_req(input logic [3:0] op);
        case (op)
            4'd0:       return "R2";
            4'd1, 4'd3: return "R3";
            4'd2, 4'd4: return "R4";
            4'd5:       return "R5";
            4'd6:       return "R6";
            4'd7:       return "R7";
            default:    return "R8";
        endcase
    endfunction

    // Driver: compute the expected result, queue it, present one request.
    task automatic drive(input logic [3:0] op, input logic [3:0] cc,
                         input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
        exp_t e;
        logic [4:0] f;
        f     = ref_flags(op, a, b, c);
        e.word = {f[3:0], 28'h0};
        e.ct   = ref_cond(cc, f[3:0]);
        e.err  = f[4];
        e.tag  = $sformatf("R1/%s/%s", op_req(op), (cc >= 4'd8 && cc <= 4'd13) ? "R10" : "R9");
        @(negedge clk);
        sbq.push_back(e);
        last_word = e.word; last_ct = e.ct; last_err = e.err;
        in_valid = 1'b1;
        sel_in   = {cc, op};
        dep1 = a; dep2 = b; dep3 = c;
    endtask

    // Monitor: every out_valid pulse must match the oldest queued result (R11).
    always @(negedge clk) begin
        if (out_valid) begin
            checks++;
            if (sbq.size() == 0) begin
                fails++;
                $display("FAIL R11: out_valid with empty scoreboard, got word=%h expected none", flags_word);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                if (flags_word !== e.word || cond_true !== e.ct || op_bad !== e.err) begin
                    fails++;
                    $display("FAIL %s sel=%h: got word=%h cond=%b bad=%b expected word=%h cond=%b bad=%b",
                             e.tag, sel_in, flags_word, cond_true, op_bad, e.word, e.ct, e.err);
                end
            end
        end
    end

    task automatic check(input string req, input logic [33:0] got, input logic [33:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    initial begin : watchdog
        #(20ns * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] vals [4];
        vals[0] = 32'h0000_0000; vals[1] = 32'h7FFF_FFFF;
        vals[2] = 32'h8000_0000; vals[3] = 32'hFFFF_FFFF;

        // R12: reset state while the reset is held, with a request pending.
        in_valid = 1'b1; sel_in = 8'hE5; dep1 = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        check("R12", {out_valid, flags_word, cond_true}, 34'd0);
        check("R12", {33'd0, op_bad}, 34'd0);
        in_valid = 1'b0;
        rst_n    = 1'b1;

        // Named corner cases.
        drive(4'd1, 4'd6, 32'h7FFF_FFFF, 32'h1, 32'h0);         // R3 overflow into sign
        drive(4'd1, 4'd0, 32'hFFFF_FFFF, 32'h1, 32'h0);         // R3 carry, zero
        drive(4'd3, 4'd6, 32'h7FFF_FFFF, 32'h0, 32'h1);         // R3 carry-in overflow
        drive(4'd2, 4'd10, 32'h8000_0000, 32'h1, 32'h0);        // R4 overflow, GE false
        drive(4'd2, 4'd9, 32'd5, 32'd5, 32'h0);                 // R4 equal: LS true
        drive(4'd2, 4'd3, 32'd3, 32'd5, 32'h0);                 // R4 borrow
        drive(4'd4, 4'd2, 32'd5, 32'd5, 32'h0);                 // R4 borrow in, C clear
        drive(4'd4, 4'd0, 32'd5, 32'd5, 32'h1);                 // R4 no borrow in, zero
        drive(4'd5, 4'd12, 32'h0, 32'hFFFF_FFF1, 32'h1);        // R5
        drive(4'd6, 4'd4, 32'h8000_0000, 32'h0, 32'h2);         // R6
        drive(4'd7, 4'd0, 32'h0, 32'h0, 32'h3);                 // R7 full zero
        drive(4'd7, 4'd0, 32'h1, 32'h0, 32'h0);                 // R7 low half nonzero
        drive(4'd7, 4'd4, 32'h0, 32'h8000_0000, 32'h1);         // R7 sign from high half

        // R3, R4, R5, R6, R7: boundary sweep over operands and carry-in.
        for (int op = 1; op <= 7; op++)
            for (int ia = 0; ia < 4; ia++)
                for (int ib = 0; ib < 4; ib++)
                    for (int ci = 0; ci < 2; ci++)
                        drive(4'(op), 4'(ia * 4 + ib + ci), vals[ia], vals[ib],
                              {30'd0, 1'(ib), 1'(ci)});

        // R2, R9, R10: every flag nibble against every condition code.
        for (int f = 0; f < 16; f++)
            for (int cc = 0; cc < 16; cc++)
                drive(4'd0, 4'(cc), {4'(f), 28'h5A5_A5A5}, 32'hFFFF_FFFF, 32'hFFFF_FFFF);

        // R8: out-of-range tags.
        for (int op = 8; op < 16; op++) begin
            drive(4'(op), 4'd14, 32'hFFFF_FFFF, 32'h1, 32'h3);
            drive(4'(op), 4'd15, 32'h0, 32'h0, 32'h0);
            drive(4'(op), 4'd1, 32'h8000_0000, 32'h0, 32'h3);
        end

        // R11: idle cycles with changing data must neither pulse nor disturb outputs.
        @(negedge clk);
        in_valid = 1'b0; sel_in = 8'h01; dep1 = 32'h1234_5678; dep2 = 32'hFFFF_FFFF;
        @(negedge clk);
        sel_in = 8'hE7; dep1 = 32'h0; dep3 = 32'h3;
        @(negedge clk);
        @(negedge clk);
        check("R11", {out_valid, flags_word, cond_true}, {1'b0, last_word, last_ct});
        check("R11", {33'd0, op_bad}, {33'd0, last_err});
        check("R11", 34'(sbq.size()), 34'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule